// File: doc/BRIEF.md
# Shadowed Control Register with Complement Check

This block stores one critical control value and guards it against upsets caused by glitches or deliberate fault injection. When the shadow option is on, a second register holds the bitwise complement of the stored value. Both copies change together on a write. A comparator checks them on every cycle, not only when the value is read. If the copies stop being exact complements, the read-error output goes high.

A chip uses one instance for each sensitive setting. The parent ORs the error outputs of all instances into one fault line, which feeds its major alert together with other fault sources. Address decoding, field legalisation and the alert handling itself belong to the surrounding logic. With the shadow option off, the block becomes a plain register and its error output is tied low.

Top module: `shadow_reg`

## Requirements
- R1: The stored width (`WIDTH`), the value loaded at reset (`RESET_VAL`) and the presence of the complement copy (`SHADOW_EN`) are set by parameters.
- R2: Reset is synchronous and active high. On the clock edge where `rst` is 1, `rd_data` becomes `RESET_VAL` and the complement copy loads `~RESET_VAL`, so `rd_error` reads 0 after that edge.
- R3: On a rising edge with `wr_en`=1 and `rst`=0, `rd_data` takes `wr_data`. With `wr_en`=0, `rd_data` keeps its value.
- R4: A write updates both copies on the same edge, the complement copy with `~wr_data`. As a result, `rd_error` stays 0 through any sequence of writes and idle cycles.
- R5: If any single bit of either copy is flipped, `rd_error` goes to 1 within the same clock cycle as the flip. No access is needed to detect it.
- R6: `rd_error` stays 1 for as long as the copies disagree. A later write restores agreement, and `rd_error` is 0 after that edge.
- R7: With `SHADOW_EN`=0, no complement copy exists and `rd_error` is constantly 0. Reads and writes behave as in R2 and R3.
- R8: `rd_data` always comes from the main copy. A flip in the complement copy leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Value to store |
| rd_data | output | WIDTH | Contents of the main copy |
| rd_error | output | 1 | High while the two copies disagree |

## Verification
The bench builds two 16-bit instances side by side, with the same inputs.
- The first has `SHADOW_EN`=1 and `RESET_VAL`=16'hA5C3. It allows bit flips to be forced into each copy separately, so the test can check immediate detection, unchanged read data and recovery on the next write.
- The second has `SHADOW_EN`=0 and `RESET_VAL`=16'h0F0F. It shows that the error output stays low in the plain variant.

Because the two reset values differ, the test can also confirm that the reset parameter is honoured per instance.

// File: rtl/shadow_reg_pkg.sv
package shadow_reg_pkg;
  // Form stored in the redundant copy for a given main value.
  function automatic logic [63:0] mirror64(input logic [63:0] v);
    return ~v;
  endfunction
endpackage

// File: rtl/shadow_reg_store.sv
module shadow_reg_store #(
  parameter int unsigned          WIDTH  = 32,
  parameter logic [WIDTH-1:0]     INIT   = '0,
  parameter bit                   INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] LOAD_VAL = INVERT ? ~INIT : INIT;

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] d_int;

  assign d_int = INVERT ? ~d : d;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= LOAD_VAL;
    end else if (we) begin
      q <= d_int;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/shadow_reg_cmp.sv
module shadow_reg_cmp #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] main_q,
  input  logic [WIDTH-1:0] shadow_q,
  output logic             mismatch
);
  logic [WIDTH-1:0] agree;

  // Each bit pair must differ: main ^ shadow is all ones when consistent.
  assign agree    = main_q ^ shadow_q;
  assign mismatch = ~(&agree);
endmodule

// File: rtl/shadow_reg.sv
module shadow_reg
  import shadow_reg_pkg::*;
#(
  parameter int unsigned      WIDTH     = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  parameter bit               SHADOW_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_error
);
  logic [WIDTH-1:0] main_q;

  shadow_reg_store #(
    .WIDTH  (WIDTH),
    .INIT   (RESET_VAL),
    .INVERT (1'b0)
  ) u_main (
    .clk (clk),
    .rst (rst),
    .we  (wr_en),
    .d   (wr_data),
    .q_o (main_q)
  );

  assign rd_data = main_q;

  if (SHADOW_EN) begin : g_shadow
    logic [WIDTH-1:0] shadow_q;

    shadow_reg_store #(
      .WIDTH  (WIDTH),
      .INIT   (RESET_VAL),
      .INVERT (1'b1)
    ) u_shadow (
      .clk (clk),
      .rst (rst),
      .we  (wr_en),
      .d   (wr_data),
      .q_o (shadow_q)
    );

    shadow_reg_cmp #(
      .WIDTH (WIDTH)
    ) u_cmp (
      .main_q   (main_q),
      .shadow_q (shadow_q),
      .mismatch (rd_error)
    );
  end else begin : g_plain
    assign rd_error = 1'b0;
  end
endmodule

// File: rtl/shadow_reg_chk.sv
module shadow_reg_chk #(
  parameter int unsigned      WIDTH     = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  parameter bit               SHADOW_EN = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_error
);
  AST_RESET_LOADS_VALUE: assert property (@(posedge clk) rst |=> (rd_data == RESET_VAL)); // R2
  AST_RESET_NO_ERROR: assert property (@(posedge clk) rst |=> !rd_error); // R2
  AST_WRITE_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data == $past(wr_data))); // R3
  AST_WRITE_RESTORES_AGREEMENT: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !rd_error); // R6

  if (!SHADOW_EN) begin : g_plain_chk
    AST_PLAIN_NEVER_ERRS: assert property (@(posedge clk) disable iff (rst) !rd_error); // R7
  end
endmodule

bind shadow_reg shadow_reg_chk #(
  .WIDTH     (WIDTH),
  .RESET_VAL (RESET_VAL),
  .SHADOW_EN (SHADOW_EN)
) u_chk (.*);

// File: tb/tb_shadow_reg.sv
`timescale 1ns/1ps
module tb_shadow_reg;
  localparam int unsigned     W      = 16;
  localparam logic [W-1:0]    RV_SH  = 16'hA5C3;
  localparam logic [W-1:0]    RV_PL  = 16'h0F0F;

  logic         clk = 1'b0;
  logic         rst;
  logic         wr_en;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data, pl_data;
  logic         rd_error, pl_error;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  shadow_reg #(.WIDTH(W), .RESET_VAL(RV_SH), .SHADOW_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rd_error(rd_error));

  shadow_reg #(.WIDTH(W), .RESET_VAL(RV_PL), .SHADOW_EN(1'b0)) dut_plain (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(pl_data), .rd_error(pl_error));

  typedef struct {
    logic [W-1:0] data;
    logic         err;
    logic [W-1:0] pdata;
    string        tag;
  } item_t;

  item_t sb[$];

  logic [W-1:0] exp_sh, exp_pl;
  logic [W-1:0] fval;

  // Monitor: compare right after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_cmp++;
        if (rd_data !== it.data) begin
          n_bad++;
          $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.data);
        end
        n_cmp++;
        if (rd_error !== it.err) begin
          n_bad++;
          $display("FAIL %s rd_error actual=%b expected=%b", it.tag, rd_error, it.err);
        end
        n_cmp++;
        if (pl_data !== it.pdata) begin
          n_bad++;
          $display("FAIL %s plain rd_data actual=%h expected=%h", it.tag, pl_data, it.pdata);
        end
        n_cmp++;
        if (pl_error !== 1'b0) begin
          n_bad++;
          $display("FAIL R7 plain rd_error actual=%b expected=0", pl_error);
        end
      end
    end
  end

  // Driver: one cycle of stimulus plus the expected result after its edge.
  task automatic step(input logic r, input logic we, input logic [W-1:0] d,
                      input logic err, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; wr_en = we; wr_data = d;
    if (r) begin
      exp_sh = RV_SH; exp_pl = RV_PL;
    end else if (we) begin
      exp_sh = d; exp_pl = d;
    end
    it.data = exp_sh; it.err = err; it.pdata = exp_pl; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 5000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    step(1, 0, 16'h0000, 0, "R1 R2 reset");
    step(1, 1, 16'hFFFF, 0, "R2 reset beats write");
    step(0, 0, 16'h1234, 0, "R3 idle holds");
    step(0, 1, 16'h0000, 0, "R3 R4 write zeros");
    step(0, 1, 16'hFFFF, 0, "R3 R4 write ones");
    step(0, 1, 16'h5AA5, 0, "R3 R4 write pattern");
    step(0, 0, 16'hDEAD, 0, "R3 hold ignores data");
    step(0, 0, 16'h0000, 0, "R4 idle no error");
    drain();

    // Flip bit 5 of the complement copy (idle cycle before, no write pending).
    @(negedge clk);
    fval = ~exp_sh ^ 16'h0020;
    force dut.g_shadow.u_shadow.q = fval;
    step(0, 0, 16'h0000, 1, "R5 R8 shadow flip");
    step(0, 0, 16'h0000, 1, "R6 error persists");
    drain();
    @(negedge clk);
    release dut.g_shadow.u_shadow.q;
    step(0, 1, 16'h3C3C, 0, "R6 write restores");
    step(0, 0, 16'h0000, 0, "R6 stays clear");
    drain();

    // Flip bit 0 of the main copy.
    @(negedge clk);
    fval = exp_sh ^ 16'h0001;
    force dut.u_main.q = fval;
    begin
      item_t it;
      @(negedge clk);
      rst = 0; wr_en = 0; wr_data = '0;
      it.data = fval; it.err = 1'b1; it.pdata = exp_pl; it.tag = "R5 main flip";
      sb.push_back(it);
    end
    drain();
    @(negedge clk);
    release dut.u_main.q;
    step(0, 1, 16'h8001, 0, "R6 write repairs main");
    step(0, 0, 16'h0000, 0, "R4 consistent again");
    step(1, 0, 16'h0000, 0, "R1 R2 reset mid-run");
    step(0, 0, 16'h0000, 0, "R2 after reset");
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule